// File: doc/BRIEF.md
# Strobed Overvoltage Confirmation Filter

This block turns a noisy output-voltage comparator flag into a clean, latched overvoltage fault for a switching converter controller. Once per switching cycle, after the power switch has turned off, it waits a fixed number of clocks so that the ringing after turn-off has died down. It then takes one sample of the flag. A fault is declared only when the flag has been found set in several back-to-back cycles. A single cycle in which the flag was not caught set starts the count over.

The surrounding controller gives the block two single-clock strobes: one when the switch turns off and one when a new oscillator cycle begins. When the fault output rises, the controller stops switching and starts its restart sequence. When that sequence wants to try again, it pulses the fault-clear input.

Top module: `ovp_strobe_filter`

## Requirements
- R1: After reset, `fault_out` is 0 and the hit count is 0.
- R2: The flag is sampled at exactly one clock edge: the edge `STROBE_DLY` clocks after the edge on which `gate_off` was captured. The flag value at any other time has no effect.
- R3: At most one sample is taken per cycle. A `gate_off` pulse that arrives after this cycle's sample has been taken is ignored until the next `cycle_start`.
- R4: If `cycle_start` arrives before the strobe delay has elapsed, no sample is taken in the cycle that ended, and that cycle counts as clean.
- R5: A cycle with no `gate_off` pulse takes no sample and counts as clean, whatever the flag does.
- R6: A sample that finds the flag at 1 adds one to the hit count. At the next `cycle_start`, a cycle whose sample did not find the flag at 1 clears the count to 0.
- R7: On the sampling edge of the `HIT_LIMIT`-th consecutive hit (default 4), `fault_out` goes to 1 and is visible after that edge. It is 0 before that edge.
- R8: `fault_out` stays at 1 until `fault_clear` is sampled high. That edge clears both the fault and the hit count. `fault_clear` takes priority over a sample on the same edge.
- R9: While the fault is latched, the hit count stays at `HIT_LIMIT` and never exceeds it or wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_off | input | 1 | One-clock strobe: the power switch has turned off |
| cycle_start | input | 1 | One-clock strobe: a new oscillator cycle begins |
| ovp_flag | input | 1 | Output-voltage comparator flag, 1 = above threshold |
| fault_clear | input | 1 | Clears the latched fault and the hit count |
| fault_out | output | 1 | Latched overvoltage fault |

## Verification
The bench holds the flag at the opposite value during the ringing interval and sets it to the intended value only around the sampling edge. A design that samples one clock early or late therefore counts the wrong cycles, and its fault pattern differs from the expected one. Three kinds of cycle try to keep a stale count alive: cycles that end before the strobe, cycles with no turn-off at all, and cycles with a second turn-off strobe carrying a set flag. A filter that skips the clear on such a cycle, or counts twice within one cycle, reaches the fault one hit too early. The bench also looks at the exact clock edge on which the fault rises. It keeps feeding hits while the fault is latched, then checks that a clear restarts the count from zero, so a counter that wraps or keeps a partial count is caught.

// File: rtl/ovp_filt_pkg.sv
package ovp_filt_pkg;

    // Phase of the strobe timer within one oscillator cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // switch not yet off in this cycle
        PH_WAIT = 2'd1,   // off, waiting out the blanking delay
        PH_DONE = 2'd2    // this cycle's single sample already taken
    } strobe_phase_e;

    // One sample event handed from the timer to the counter.
    typedef struct packed {
        logic fire;   // sampling edge of this cycle
        logic flag;   // comparator value captured there
    } sample_t;

    // Operation applied to the consecutive-hit counter.
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_CLR  = 2'd2
    } cnt_op_e;

    // Saturating increment used by the hit counter.
    function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

endpackage

// File: rtl/ovp_strobe_timer.sv
module ovp_strobe_timer
    import ovp_filt_pkg::*;
#(
    parameter int unsigned STROBE_DLY = 220
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    gate_off,
    input  logic    cycle_start,
    input  logic    flag_in,
    output sample_t smp
);
    localparam int unsigned TW = $clog2(STROBE_DLY + 1);
    localparam logic [TW-1:0] DLY_V = TW'(STROBE_DLY);
    localparam logic [TW-1:0] ONE_V = TW'(1);

    strobe_phase_e phase_q;
    logic [TW-1:0] elapsed_q;
    logic          at_strobe;

    assign at_strobe = (phase_q == PH_WAIT) && (elapsed_q == DLY_V);

    // A new cycle or a fresh turn-off on the same edge cancels the sample.
    always_comb begin
        smp.fire = at_strobe && !cycle_start && !gate_off;
        smp.flag = flag_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            elapsed_q <= '0;
        end else if (cycle_start) begin
            phase_q   <= gate_off ? PH_WAIT : PH_IDLE;
            elapsed_q <= ONE_V;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (gate_off) begin
                        phase_q   <= PH_WAIT;
                        elapsed_q <= ONE_V;
                    end
                end
                PH_WAIT: begin
                    if (gate_off) begin
                        elapsed_q <= ONE_V;
                    end else if (elapsed_q == DLY_V) begin
                        phase_q <= PH_DONE;
                    end else begin
                        elapsed_q <= elapsed_q + ONE_V;
                    end
                end
                PH_DONE: phase_q <= PH_DONE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ovp_hit_counter.sv
module ovp_hit_counter
    import ovp_filt_pkg::*;
#(
    parameter int unsigned HIT_LIMIT = 4,
    parameter int unsigned CW = $clog2(HIT_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fault_clear,
    input  logic          cycle_start,
    input  logic          fault_q,
    input  sample_t       smp,
    output logic [CW-1:0] hit_cnt,
    output logic          limit_reached
);
    localparam logic [CW-1:0] LAST_V = CW'(HIT_LIMIT - 1);

    logic    cyc_hit_q;
    cnt_op_e op;

    always_comb begin
        if (fault_clear)             op = CNT_CLR;
        else if (fault_q)            op = CNT_HOLD;
        else if (cycle_start)        op = cyc_hit_q ? CNT_HOLD : CNT_CLR;
        else if (smp.fire && smp.flag) op = CNT_INC;
        else                         op = CNT_HOLD;
    end

    assign limit_reached = (op == CNT_INC) && (hit_cnt == LAST_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_cnt   <= '0;
            cyc_hit_q <= 1'b0;
        end else begin
            unique case (op)
                CNT_CLR:  hit_cnt <= '0;
                CNT_INC:  hit_cnt <= CW'(sat_inc(int'(hit_cnt), HIT_LIMIT));
                default:  hit_cnt <= hit_cnt;
            endcase
            if (fault_clear || cycle_start)
                cyc_hit_q <= 1'b0;
            else if (smp.fire && smp.flag)
                cyc_hit_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ovp_fault_latch.sv
module ovp_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clear_i,
    output logic fault_q
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) fault_q <= 1'b0;
        else if (set_i)     fault_q <= 1'b1;
    end
endmodule

// File: rtl/ovp_strobe_filter.sv
module ovp_strobe_filter
    import ovp_filt_pkg::*;
#(
    parameter int unsigned STROBE_DLY = 220,
    parameter int unsigned HIT_LIMIT  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_off,
    input  logic cycle_start,
    input  logic ovp_flag,
    input  logic fault_clear,
    output logic fault_out
);
    localparam int unsigned CW = $clog2(HIT_LIMIT + 1);

    sample_t       smp;
    logic          smp_fire;
    logic [CW-1:0] hit_cnt;
    logic          limit_reached;

    assign smp_fire = smp.fire;

    ovp_strobe_timer #(.STROBE_DLY(STROBE_DLY)) u_timer (
        .clk(clk), .rst(rst), .gate_off(gate_off), .cycle_start(cycle_start),
        .flag_in(ovp_flag), .smp(smp)
    );

    ovp_hit_counter #(.HIT_LIMIT(HIT_LIMIT), .CW(CW)) u_count (
        .clk(clk), .rst(rst), .fault_clear(fault_clear), .cycle_start(cycle_start),
        .fault_q(fault_out), .smp(smp), .hit_cnt(hit_cnt),
        .limit_reached(limit_reached)
    );

    ovp_fault_latch u_latch (
        .clk(clk), .rst(rst), .set_i(limit_reached), .clear_i(fault_clear),
        .fault_q(fault_out)
    );
endmodule

// File: rtl/ovp_strobe_filter_chk.sv
module ovp_strobe_filter_chk #(
    parameter int unsigned STROBE_DLY = 220,
    parameter int unsigned HIT_LIMIT  = 4,
    parameter int unsigned CW = $clog2(HIT_LIMIT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          gate_off,
    input logic          cycle_start,
    input logic          ovp_flag,
    input logic          fault_clear,
    input logic          fault_out,
    input logic          smp_fire,
    input logic [CW-1:0] hit_cnt
);
    localparam int unsigned TW = $clog2(STROBE_DLY + 2);
    localparam logic [TW-1:0] TOP_V = TW'(STROBE_DLY + 1);

    logic [TW-1:0] since_off;
    logic          seen_smp;

    // Clocks since the last turn-off strobe, saturating past the delay.
    always_ff @(posedge clk) begin
        if (rst)                    since_off <= '0;
        else if (gate_off)          since_off <= TW'(1);
        else if (since_off != TOP_V && since_off != '0)
                                    since_off <= since_off + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || cycle_start) seen_smp <= 1'b0;
        else if (smp_fire)      seen_smp <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!fault_out && hit_cnt == '0));

    p_strobe_delay_r2: assert property (@(posedge clk) disable iff (rst)
        smp_fire |-> (since_off == TW'(STROBE_DLY)));

    p_one_sample_r3: assert property (@(posedge clk) disable iff (rst)
        !(seen_smp && smp_fire));

    p_fault_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_out) |-> $past(smp_fire && ovp_flag && !fault_clear));

    p_latched_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_out && !fault_clear) |=> fault_out);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        fault_clear |=> (!fault_out && hit_cnt == '0));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        hit_cnt <= CW'(HIT_LIMIT));

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        fault_out |-> (hit_cnt == CW'(HIT_LIMIT)));
endmodule

bind ovp_strobe_filter ovp_strobe_filter_chk #(
    .STROBE_DLY(STROBE_DLY), .HIT_LIMIT(HIT_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .gate_off(gate_off), .cycle_start(cycle_start),
    .ovp_flag(ovp_flag), .fault_clear(fault_clear), .fault_out(fault_out),
    .smp_fire(smp_fire), .hit_cnt(hit_cnt)
);

// File: tb/ovp_strobe_filter_tb.sv
module ovp_strobe_filter_tb_top;
    localparam int unsigned DLY = 6;
    localparam int unsigned LIM = 4;

    // Cycle kinds: 0 normal, 1 ends before strobe, 2 no turn-off, 3 double turn-off
    typedef struct packed {
        logic [1:0] mode;
        logic       v;
        logic       exp_fault;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 1'b0},   // R6 hit 1
        '{2'd0, 1'b1, 1'b0},   // R6 hit 2
        '{2'd0, 1'b1, 1'b0},   // R6 hit 3
        '{2'd0, 1'b0, 1'b0},   // R2 flag high only while ringing: clean, clears
        '{2'd0, 1'b1, 1'b0},
        '{2'd0, 1'b1, 1'b0},
        '{2'd0, 1'b1, 1'b0},
        '{2'd1, 1'b1, 1'b0},   // R4 cycle ends before strobe: clean
        '{2'd0, 1'b1, 1'b0},
        '{2'd0, 1'b1, 1'b0},
        '{2'd0, 1'b1, 1'b0},
        '{2'd0, 1'b1, 1'b1},   // R7 fourth consecutive hit
        '{2'd0, 1'b0, 1'b1},   // R8 latched through clean cycle
        '{2'd0, 1'b1, 1'b1}    // R9 more hits while latched
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gate_off = 1'b0;
    logic cycle_start = 1'b0;
    logic ovp_flag = 1'b0;
    logic fault_clear = 1'b0;
    logic fault_out;

    int n_chk = 0;
    int n_bad = 0;
    logic pre_f, post_f;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ovp_strobe_filter #(.STROBE_DLY(DLY), .HIT_LIMIT(LIM)) dut_i (
        .clk(clk), .rst(rst), .gate_off(gate_off), .cycle_start(cycle_start),
        .ovp_flag(ovp_flag), .fault_clear(fault_clear), .fault_out(fault_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: fault_out=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic run_cycle(input logic v, input int mode);
        @(negedge clk);
        cycle_start = 1'b1;
        ovp_flag = ~v;
        @(negedge clk);
        cycle_start = 1'b0;
        if (mode == 2) begin
            ovp_flag = 1'b1;
            repeat (DLY + 4) @(negedge clk);
            return;
        end
        gate_off = 1'b1;                       // captured at edge E0
        @(negedge clk);
        gate_off = 1'b0;
        ovp_flag = (mode == 1) ? 1'b1 : ~v;    // ringing interval
        if (mode == 1) begin
            repeat (DLY - 3) @(negedge clk);
            return;
        end
        repeat (DLY - 1) @(negedge clk);
        pre_f = fault_out;                     // before sampling edge
        ovp_flag = v;
        @(negedge clk);
        post_f = fault_out;                    // after sampling edge
        ovp_flag = ~v;
        if (mode == 3) begin
            @(negedge clk);
            gate_off = 1'b1;
            ovp_flag = 1'b1;
            @(negedge clk);
            gate_off = 1'b0;
            repeat (DLY + 3) @(negedge clk);
            return;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", fault_out, 1'b0);

        for (int i = 0; i < NV; i++) begin
            run_cycle(VEC[i].v, int'(VEC[i].mode));
            check($sformatf("R6/R7 vector %0d", i), fault_out, VEC[i].exp_fault);
        end

        // R9: keep hitting while latched, then clear must restart from zero
        for (int i = 0; i < 8; i++) run_cycle(1'b1, 0);
        check("R9 latched under extra hits", fault_out, 1'b1);
        do_clear();
        check("R8 clear drops fault", fault_out, 1'b0);
        for (int i = 0; i < 3; i++) run_cycle(1'b1, 0);
        check("R8 count restarted by clear", fault_out, 1'b0);
        run_cycle(1'b1, 0);
        check("R7 rises exactly after sample edge (before)", pre_f, 1'b0);
        check("R7 rises exactly after sample edge (after)", post_f, 1'b1);

        // R5: a cycle without turn-off is clean
        do_clear();
        for (int i = 0; i < 3; i++) run_cycle(1'b1, 0);
        run_cycle(1'b1, 2);
        run_cycle(1'b1, 0);
        check("R5 no-turn-off cycle clears count", fault_out, 1'b0);

        // R3: a second turn-off with the flag set takes no second sample
        do_clear();
        for (int i = 0; i < 3; i++) run_cycle(1'b1, 0);
        run_cycle(1'b0, 3);
        run_cycle(1'b1, 0);
        check("R3 second turn-off ignored", fault_out, 1'b0);
        for (int i = 0; i < 3; i++) run_cycle(1'b1, 0);
        check("R3 four hits after reset of count", fault_out, 1'b1);

        // R8: clear on the same edge as the fourth sample wins
        do_clear();
        for (int i = 0; i < 3; i++) run_cycle(1'b1, 0);
        fork
            run_cycle(1'b1, 0);
            begin
                repeat (DLY + 2) @(negedge clk);
                fault_clear = 1'b1;
                @(negedge clk);
                fault_clear = 1'b0;
            end
        join
        check("R8 clear beats sample on same edge", fault_out, 1'b0);

        // R1: reset clears a latched fault
        for (int i = 0; i < 4; i++) run_cycle(1'b1, 0);
        check("R1 fault set before reset", fault_out, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears fault", fault_out, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule